// File: doc/BRIEF.md
# Packet Stream Generator and Loopback Checker

This block drives a fixed run of equal-length packets onto a streaming transmit port. Every word of every packet comes from a known formula. The same packets return on a streaming receive port after an external loopback path. The block then checks them word by word without storing any of them. The receive side works out each expected word on its own, from a local packet counter.

Outputs are the following:
- counters for start and end markers, one set for each direction;
- a count of out-of-order packets;
- a count of corrupted payload words;
- a count of CRC error pulses reported by the link.

A registered pass flag rises once the whole run has been sent, every packet has come back, and no error of any kind was seen. A clear input returns the block to its idle state, so the same run can be repeated.

Top module: `pkt_loop_tester`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, the following are all zero or low: every counter, `tx_valid`, `gen_done` and `pass`.
- R2: A run starts only when `start` is high in a cycle where `link_up` is high. A `start` pulse while `link_up` is low has no effect: `tx_valid` stays low and `tx_sop_cnt` stays zero.
- R3: A run sends exactly NUM_PKTS packets of PKT_WORDS words each. `tx_sop` is high on the first word of a packet and `tx_eop` on its last word. After the last word, `tx_valid` drops and `gen_done` stays high until a clear.
- R4: Word 0 of packet p (counting from 0) carries p. Word k of the same packet, for k >= 1, carries ((p << 8) | k) XOR 0x5A000000, with DATA_W = 32.
- R5: A word is transferred only in a cycle where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` keep their values into the next cycle.
- R6: Four counters count marker beats:
  - `tx_sop_cnt` and `tx_eop_cnt` count transferred transmit words that carry each marker;
  - `rx_sop_cnt` and `rx_eop_cnt` count receive words with `rx_valid` high that carry each marker.
- R7: The first word of each received packet is compared with an expected sequence number. That number starts at 0 and steps by one on every received start marker. A mismatch adds exactly one to `seq_err_cnt`.
- R8: Every other received word is compared with the R4 pattern, using that packet's expected sequence number and the word's position since the start marker. Each mismatching word adds one to `data_err_cnt`.
- R9: Each cycle with `crc_err` high adds one to `crc_err_cnt`. All counters saturate at their maximum value.
- R10: `pass` goes high one cycle after all of the following hold together: the run is done, the transmit and receive start counts are equal, the transmit and receive end counts are equal, the receive counts equal NUM_PKTS, and all three error counters are zero. Otherwise `pass` is low.
- R11: `clr` returns the generator to idle, so a later `start` repeats the full run from packet 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and generator |
| start | input | 1 | Begin a run (accepted only while link_up is high) |
| link_up | input | 1 | Link ready indication |
| crc_err | input | 1 | One-cycle CRC error pulse from the link |
| tx_ready | input | 1 | Downstream ready on the transmit stream |
| tx_valid | output | 1 | Transmit word valid |
| tx_sop | output | 1 | First word of packet on transmit |
| tx_eop | output | 1 | Last word of packet on transmit |
| tx_data | output | 32 | Transmit word |
| rx_valid | input | 1 | Receive word valid |
| rx_sop | input | 1 | First word of packet on receive |
| rx_eop | input | 1 | Last word of packet on receive |
| rx_data | input | 32 | Receive word |
| tx_sop_cnt | output | 16 | Transmitted start markers |
| tx_eop_cnt | output | 16 | Transmitted end markers |
| rx_sop_cnt | output | 16 | Received start markers |
| rx_eop_cnt | output | 16 | Received end markers |
| seq_err_cnt | output | 16 | Out-of-order packets |
| data_err_cnt | output | 16 | Mismatching payload words |
| crc_err_cnt | output | 16 | Link CRC error pulses |
| gen_done | output | 1 | Generator has sent the whole run |
| pass | output | 1 | Run fully accounted for with no errors |

## Verification
The assertions check the following on every cycle:
- the transmit word is held steady under backpressure;
- a run starts only from an accepted start;
- the start-marker, CRC and error counters each step by at most one per cycle;
- `pass` never appears without `gen_done` or with an error already counted.

Only the bench scenarios can show the rest. These cover the exact word pattern and the marker placement over a full run under random backpressure, and end-to-end agreement of the counts through the loopback. They also show that one corrupted sequence word costs a single sequence error with no knock-on payload errors, and that a clear makes a second run start again from packet 0.

// File: rtl/pkt_loop_pkg.sv
package pkt_loop_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam word_t PAT_SALT = word_t'(32'h5A00_0000);

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_SEND = 2'd1,
        GEN_DONE = 2'd2
    } gen_state_e;

    // Expected content of word idx of packet seq.
    function automatic word_t pat_word(input word_t seq, input word_t idx);
        word_t r;
        if (idx == '0) begin
            r = seq;
        end else begin
            r = ((seq << 8) | idx) ^ PAT_SALT;
        end
        return r;
    endfunction

    // Saturating counter step.
    function automatic cnt_t sat_inc(input cnt_t c, input logic en);
        cnt_t r;
        r = c;
        if (en && (c != '1)) begin
            r = c + cnt_t'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pkt_gen.sv
module pkt_gen
    import pkt_loop_pkg::*;
#(
    parameter int PKT_WORDS = 8,
    parameter int NUM_PKTS  = 100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  start,
    input  logic  link_up,
    input  logic  tx_ready,
    output logic  tx_valid,
    output logic  tx_sop,
    output logic  tx_eop,
    output word_t tx_data,
    output cnt_t  tx_sop_cnt,
    output cnt_t  tx_eop_cnt,
    output logic  gen_done
);

    localparam int PKT_W = $clog2(NUM_PKTS + 1);
    localparam int WRD_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;
    localparam logic [PKT_W-1:0] LAST_PKT = PKT_W'(NUM_PKTS - 1);
    localparam logic [WRD_W-1:0] LAST_WRD = WRD_W'(PKT_WORDS - 1);

    gen_state_e       state;
    logic [PKT_W-1:0] pkt_idx;
    logic [WRD_W-1:0] wrd_idx;
    logic             beat;

    assign tx_valid = (state == GEN_SEND);
    assign tx_sop   = (wrd_idx == '0);
    assign tx_eop   = (wrd_idx == LAST_WRD);
    assign tx_data  = pat_word(word_t'(pkt_idx), word_t'(wrd_idx));
    assign beat     = tx_valid && tx_ready;
    assign gen_done = (state == GEN_DONE);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state   <= GEN_IDLE;
            pkt_idx <= '0;
            wrd_idx <= '0;
        end else begin
            case (state)
                GEN_IDLE: begin
                    if (start && link_up) begin
                        state <= GEN_SEND;
                    end
                end
                GEN_SEND: begin
                    if (beat) begin
                        if (wrd_idx == LAST_WRD) begin
                            wrd_idx <= '0;
                            if (pkt_idx == LAST_PKT) begin
                                state <= GEN_DONE;
                            end else begin
                                pkt_idx <= pkt_idx + 1'b1;
                            end
                        end else begin
                            wrd_idx <= wrd_idx + 1'b1;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tx_sop_cnt <= '0;
            tx_eop_cnt <= '0;
        end else begin
            tx_sop_cnt <= sat_inc(tx_sop_cnt, beat && tx_sop);
            tx_eop_cnt <= sat_inc(tx_eop_cnt, beat && tx_eop);
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst || clr)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop))) // R5
        else $error("transmit word changed while stalled");

    AST_START_GATE: assert property (@(posedge clk) disable iff (rst || clr)
        $rose(tx_valid) |-> $past(start && link_up)) // R2
        else $error("transmit began without an accepted start");

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst || clr)
        gen_done |=> (gen_done && !tx_valid)) // R3
        else $error("generator left done state without clear");

endmodule

// File: rtl/pkt_chk.sv
module pkt_chk
    import pkt_loop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  rx_valid,
    input  logic  rx_sop,
    input  logic  rx_eop,
    input  word_t rx_data,
    output cnt_t  rx_sop_cnt,
    output cnt_t  rx_eop_cnt,
    output cnt_t  seq_err_cnt,
    output cnt_t  data_err_cnt
);

    word_t exp_seq;   // sequence number the next start word must carry
    word_t cur_seq;   // expected sequence number of the packet in flight
    word_t rx_idx;    // word position since the last start marker
    logic  seq_bad;
    logic  data_bad;

    assign seq_bad  = rx_valid && rx_sop && (rx_data != exp_seq);
    assign data_bad = rx_valid && !rx_sop && (rx_data != pat_word(cur_seq, rx_idx));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            exp_seq <= '0;
            cur_seq <= '0;
            rx_idx  <= '0;
        end else if (rx_valid) begin
            if (rx_sop) begin
                cur_seq <= exp_seq;
                exp_seq <= exp_seq + word_t'(1);
                rx_idx  <= word_t'(1);
            end else begin
                rx_idx  <= rx_idx + word_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rx_sop_cnt   <= '0;
            rx_eop_cnt   <= '0;
            seq_err_cnt  <= '0;
            data_err_cnt <= '0;
        end else begin
            rx_sop_cnt   <= sat_inc(rx_sop_cnt, rx_valid && rx_sop);
            rx_eop_cnt   <= sat_inc(rx_eop_cnt, rx_valid && rx_eop);
            seq_err_cnt  <= sat_inc(seq_err_cnt, seq_bad);
            data_err_cnt <= sat_inc(data_err_cnt, data_bad);
        end
    end

    AST_RX_SOP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!clr && rx_valid && rx_sop && (rx_sop_cnt != '1)) |=> (rx_sop_cnt == $past(rx_sop_cnt) + cnt_t'(1))) // R6
        else $error("receive start marker not counted");

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((seq_err_cnt == $past(seq_err_cnt)) || (seq_err_cnt == $past(seq_err_cnt) + cnt_t'(1)))) // R7
        else $error("sequence error count jumped");

    AST_DATA_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((data_err_cnt == $past(data_err_cnt)) || (data_err_cnt == $past(data_err_cnt) + cnt_t'(1)))) // R8
        else $error("payload error count jumped");

endmodule

// File: rtl/pkt_judge.sv
module pkt_judge
    import pkt_loop_pkg::*;
#(
    parameter int NUM_PKTS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic crc_err,
    input  logic gen_done,
    input  cnt_t tx_sop_cnt,
    input  cnt_t tx_eop_cnt,
    input  cnt_t rx_sop_cnt,
    input  cnt_t rx_eop_cnt,
    input  cnt_t seq_err_cnt,
    input  cnt_t data_err_cnt,
    output cnt_t crc_err_cnt,
    output logic pass
);

    localparam cnt_t TARGET = cnt_t'(NUM_PKTS);

    logic counts_match;
    logic no_errors;

    assign counts_match = (tx_sop_cnt == rx_sop_cnt) && (tx_eop_cnt == rx_eop_cnt)
                       && (rx_sop_cnt == TARGET) && (rx_eop_cnt == TARGET);
    assign no_errors    = (seq_err_cnt == '0) && (data_err_cnt == '0) && (crc_err_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_err_cnt <= '0;
            pass        <= 1'b0;
        end else begin
            crc_err_cnt <= sat_inc(crc_err_cnt, crc_err);
            pass        <= gen_done && counts_match && no_errors;
        end
    end

    AST_CRC_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!clr && crc_err && (crc_err_cnt != '1)) |=> (crc_err_cnt == $past(crc_err_cnt) + cnt_t'(1))) // R9
        else $error("CRC pulse not counted");

    AST_PASS_DONE: assert property (@(posedge clk) disable iff (rst || clr)
        pass |-> gen_done) // R10
        else $error("pass without finished generator");

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst || clr)
        $rose(pass) |-> ($past(seq_err_cnt) == '0 && $past(data_err_cnt) == '0 && $past(crc_err_cnt) == '0)) // R10
        else $error("pass raised with errors counted");

endmodule

// File: rtl/pkt_loop_tester.sv
module pkt_loop_tester
    import pkt_loop_pkg::*;
#(
    parameter int PKT_WORDS = 8,
    parameter int NUM_PKTS  = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        start,
    input  logic        link_up,
    input  logic        crc_err,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic        tx_sop,
    output logic        tx_eop,
    output logic [31:0] tx_data,
    input  logic        rx_valid,
    input  logic        rx_sop,
    input  logic        rx_eop,
    input  logic [31:0] rx_data,
    output logic [15:0] tx_sop_cnt,
    output logic [15:0] tx_eop_cnt,
    output logic [15:0] rx_sop_cnt,
    output logic [15:0] rx_eop_cnt,
    output logic [15:0] seq_err_cnt,
    output logic [15:0] data_err_cnt,
    output logic [15:0] crc_err_cnt,
    output logic        gen_done,
    output logic        pass
);

    pkt_gen #(
        .PKT_WORDS (PKT_WORDS),
        .NUM_PKTS  (NUM_PKTS)
    ) u_gen (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .start      (start),
        .link_up    (link_up),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_sop     (tx_sop),
        .tx_eop     (tx_eop),
        .tx_data    (tx_data),
        .tx_sop_cnt (tx_sop_cnt),
        .tx_eop_cnt (tx_eop_cnt),
        .gen_done   (gen_done)
    );

    pkt_chk u_chk (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .rx_valid     (rx_valid),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .rx_data      (rx_data),
        .rx_sop_cnt   (rx_sop_cnt),
        .rx_eop_cnt   (rx_eop_cnt),
        .seq_err_cnt  (seq_err_cnt),
        .data_err_cnt (data_err_cnt)
    );

    pkt_judge #(
        .NUM_PKTS (NUM_PKTS)
    ) u_judge (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .crc_err      (crc_err),
        .gen_done     (gen_done),
        .tx_sop_cnt   (tx_sop_cnt),
        .tx_eop_cnt   (tx_eop_cnt),
        .rx_sop_cnt   (rx_sop_cnt),
        .rx_eop_cnt   (rx_eop_cnt),
        .seq_err_cnt  (seq_err_cnt),
        .data_err_cnt (data_err_cnt),
        .crc_err_cnt  (crc_err_cnt),
        .pass         (pass)
    );

endmodule

// File: tb/sim_pkt_loop_tester.sv
module sim_pkt_loop_tester;

    localparam int CLK_PERIOD = 10;
    localparam int PKT_WORDS  = 8;
    localparam int NUM_PKTS   = 100;

    logic        clk = 1'b0;
    logic        rst, clr, start, link_up, crc_err, tx_ready;
    logic        tx_valid, tx_sop, tx_eop;
    logic [31:0] tx_data;
    logic        rx_valid, rx_sop, rx_eop;
    logic [31:0] rx_data;
    logic [15:0] tx_sop_cnt, tx_eop_cnt, rx_sop_cnt, rx_eop_cnt;
    logic [15:0] seq_err_cnt, data_err_cnt, crc_err_cnt;
    logic        gen_done, pass;

    typedef struct {
        logic [31:0] data;
        logic        sop;
        logic        eop;
        int          pkt;
        int          wrd;
    } item_t;

    item_t exp_q[$];
    item_t loop_q[$];

    int checks = 0;
    int errors = 0;
    bit corrupt_en = 0;
    bit ready_rand = 0;
    bit finished = 0;
    bit prev_stall = 0;
    logic [31:0] prev_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_loop_tester #(.PKT_WORDS(PKT_WORDS), .NUM_PKTS(NUM_PKTS)) u0 (
        .clk(clk), .rst(rst), .clr(clr), .start(start), .link_up(link_up),
        .crc_err(crc_err), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
        .tx_sop_cnt(tx_sop_cnt), .tx_eop_cnt(tx_eop_cnt),
        .rx_sop_cnt(rx_sop_cnt), .rx_eop_cnt(rx_eop_cnt),
        .seq_err_cnt(seq_err_cnt), .data_err_cnt(data_err_cnt),
        .crc_err_cnt(crc_err_cnt), .gen_done(gen_done), .pass(pass)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Word pattern as stated in R4.
    function automatic logic [31:0] exp_word(input int p, input int w);
        if (w == 0) return 32'(p);
        return ((32'(p) << 8) | 32'(w)) ^ 32'h5A00_0000;
    endfunction

    // Driver side of the scoreboard: one expected item per transmit word.
    task automatic push_expected();
        for (int p = 0; p < NUM_PKTS; p++) begin
            for (int w = 0; w < PKT_WORDS; w++) begin
                item_t it;
                it.data = exp_word(p, w);
                it.sop  = (w == 0);
                it.eop  = (w == PKT_WORDS - 1);
                it.pkt  = p;
                it.wrd  = w;
                exp_q.push_back(it);
            end
        end
    endtask

    // Monitor: pops the expected item for each transferred word and forwards it to the loopback.
    always @(posedge clk) begin
        if (rst) begin
            prev_stall = 0;
        end else begin
            if (prev_stall) check("R5", "data held under stall", tx_data, prev_data);
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check("R3", "word beyond the run", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check("R4", "tx word", tx_data, it.data);
                    check("R3", "tx sop marker", tx_sop, it.sop);
                    check("R3", "tx eop marker", tx_eop, it.eop);
                    loop_q.push_back(it);
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
        end
    end

    // Loopback path with optional corruption.
    always @(negedge clk) begin
        if (loop_q.size() > 0) begin
            item_t it;
            logic [31:0] d;
            it = loop_q.pop_front();
            d  = it.data;
            if (corrupt_en && it.pkt == 5  && it.wrd == 3) d = d ^ 32'h1;
            if (corrupt_en && it.pkt == 10 && it.wrd == 0) d = d ^ 32'h1;
            rx_valid = 1'b1;
            rx_sop   = it.sop;
            rx_eop   = it.eop;
            rx_data  = d;
        end else begin
            rx_valid = 1'b0;
            rx_sop   = 1'b0;
            rx_eop   = 1'b0;
            rx_data  = '0;
        end
    end

    always @(negedge clk) begin
        tx_ready = ready_rand ? ($urandom_range(3) != 0) : 1'b1;
    end

    task automatic check_all_zero(input string req);
        check(req, "tx_valid", tx_valid, 0);
        check(req, "tx_sop_cnt", tx_sop_cnt, 0);
        check(req, "tx_eop_cnt", tx_eop_cnt, 0);
        check(req, "rx_sop_cnt", rx_sop_cnt, 0);
        check(req, "rx_eop_cnt", rx_eop_cnt, 0);
        check(req, "seq_err_cnt", seq_err_cnt, 0);
        check(req, "data_err_cnt", data_err_cnt, 0);
        check(req, "crc_err_cnt", crc_err_cnt, 0);
        check(req, "gen_done", gen_done, 0);
        check(req, "pass", pass, 0);
    endtask

    task automatic wait_drain();
        while (!gen_done) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; clr = 1'b0; start = 1'b0; link_up = 1'b0; crc_err = 1'b0;
        tx_ready = 1'b1;
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all_zero("R1");

        // R2: start with the link down is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check("R2", "tx_valid with link down", tx_valid, 0);
        check("R2", "tx_sop_cnt with link down", tx_sop_cnt, 0);

        // Clean run under random backpressure
        push_expected();
        ready_rand = 1;
        link_up = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        check("R10", "pass mid-run", pass, 0);
        check("R3", "gen_done mid-run", gen_done, 0);
        wait_drain();
        check("R3", "words left unsent", exp_q.size(), 0);
        check("R3", "tx_valid after run", tx_valid, 0);
        check("R3", "gen_done after run", gen_done, 1);
        check("R6", "tx_sop_cnt", tx_sop_cnt, NUM_PKTS);
        check("R6", "tx_eop_cnt", tx_eop_cnt, NUM_PKTS);
        check("R6", "rx_sop_cnt", rx_sop_cnt, NUM_PKTS);
        check("R6", "rx_eop_cnt", rx_eop_cnt, NUM_PKTS);
        check("R7", "seq_err_cnt clean", seq_err_cnt, 0);
        check("R8", "data_err_cnt clean", data_err_cnt, 0);
        check("R9", "crc_err_cnt clean", crc_err_cnt, 0);
        check("R10", "pass after clean run", pass, 1);

        // R11: clear
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check_all_zero("R11");

        // Second run with corruption and CRC pulses
        push_expected();
        ready_rand = 0;
        corrupt_en = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            crc_err = 1'b1;
            @(negedge clk);
            crc_err = 1'b0;
            @(negedge clk);
        end
        check("R9", "crc_err_cnt after pulses", crc_err_cnt, 3);
        wait_drain();
        check("R11", "second run restarted from packet 0", exp_q.size(), 0);
        check("R6", "tx_sop_cnt run 2", tx_sop_cnt, NUM_PKTS);
        check("R6", "rx_eop_cnt run 2", rx_eop_cnt, NUM_PKTS);
        check("R7", "seq_err_cnt single bad seq", seq_err_cnt, 1);
        check("R8", "data_err_cnt single bad word", data_err_cnt, 1);
        check("R9", "crc_err_cnt final", crc_err_cnt, 3);
        check("R10", "pass with errors", pass, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule